// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller

This block gathers 64 level-sensitive interrupt inputs and presents them to a processor through two request lines. One line is for normal interrupts and one is for fast interrupts. Software programs the block through a small 32-bit register port. For every source it chooses an enable, a path (normal or fast) and a 4-bit priority. It can also force a source active without its input. A global threshold hides low-priority normal interrupts.

Two read-only vector words name the winning source on each path. The normal path names the source with the highest priority value; a tie goes to the larger source number. The fast path names the largest pending source number. A handler reads the vector word, services the device and, where needed, uses the number registers to drop or restore one enable bit without a read-modify-write. Enable bits change only through these number registers or through direct writes to the enable words.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After synchronous reset the control word (0x00) reads 0. The threshold (0x04) reads 0x1f. All enable, path, priority and force words read 0. Both request outputs are low and both vector words (0x40, 0x44) read 0xFFFF_FFFF.
- R2: Writing a value v in the range 0..63 to 0x08 sets the enable of source v and changes no other enable. A value of 64 or more changes nothing.
- R3: Writing a value v in the range 0..63 to 0x0C clears the enable of source v and changes no other enable. A value of 64 or more changes nothing.
- R4: Each per-source word pair holds sources 32..63 at the lower address and sources 0..31 at the higher address, with source n at bit n%32. The pairs are: enable 0x10/0x14, path 0x18/0x1C, raw input 0x48/0x4C, force 0x50/0x54, normal pending 0x58/0x5C and fast pending 0x60/0x64. The enable, path and force words are read/write. The raw input and pending words are read-only.
- R5: The priority of source n sits in bits [4*(n%8)+3 : 4*(n%8)] of the word at 0x20 + 4*(7 - n/8). So sources 0..7 are at 0x3C and sources 56..63 are at 0x20.
- R6: A source is active when its raw input or its force bit is 1. It is pending-normal when it is active, enabled and its path bit is 0. It is pending-fast when it is active, enabled and its path bit is 1.
- R7: The normal vector word (0x40) gives the winning source number in bits [21:16] and its priority in bits [3:0], with all other bits 0. The winner is the eligible pending-normal source with the largest priority value; among equal priorities the larger source number wins. With no eligible source the word reads 0xFFFF_FFFF.
- R8: When the threshold reads 0x1f, every pending-normal source is eligible. For any other threshold value, a pending-normal source is eligible only when its priority is greater than threshold bits [3:0].
- R9: The fast vector word (0x44) gives the largest pending-fast source number in bits [5:0], with all other bits 0. With nothing pending-fast it reads 0xFFFF_FFFF.
- R10: The normal request output is high exactly when an eligible pending-normal source exists. The fast request output is high exactly when any source is pending-fast.
- R11: Writes take effect at the clock edge that samples them, and reads are combinational from the current state. The control word at 0x00 stores all 32 bits. The number registers and unmapped addresses read 0. Writes to read-only addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src_i | input | 64 | Level-sensitive interrupt inputs, bit n is source n |
| bus_addr | input | 8 | Register byte address |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| nirq_o | output | 1 | Normal interrupt request |
| firq_o | output | 1 | Fast interrupt request |

## Verification
The hardest states to reach are ties and threshold edges in the normal arbiter. Several eligible sources share one priority value, or a winner's priority equals the threshold exactly, while a second source sits one step above it. Random stimulus rarely lines these up, so directed steps place equal priorities at sources 1 and 63 and then sweep the threshold across that value. Random phases draw priorities from a narrow range and keep the input pattern sparse. This makes ties and masking boundaries frequent. A bench model then computes every readable word after each step.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
    localparam int NSRC   = 64;
    localparam int HALF   = NSRC / 2;
    localparam int PW     = 4;
    localparam int DW     = 32;
    localparam int AW     = 8;
    localparam int IDW    = $clog2(NSRC);
    localparam int PER_W  = DW / PW;
    localparam int NBANK  = NSRC / PER_W;

    localparam logic [AW-1:0] A_CTRL  = 8'h00;
    localparam logic [AW-1:0] A_THR   = 8'h04;
    localparam logic [AW-1:0] A_ENSET = 8'h08;
    localparam logic [AW-1:0] A_ENCLR = 8'h0C;
    localparam logic [AW-1:0] A_ENH   = 8'h10;
    localparam logic [AW-1:0] A_ENL   = 8'h14;
    localparam logic [AW-1:0] A_TYH   = 8'h18;
    localparam logic [AW-1:0] A_TYL   = 8'h1C;
    localparam logic [AW-1:0] A_PRIO  = 8'h20;
    localparam logic [AW-1:0] A_NVEC  = 8'h40;
    localparam logic [AW-1:0] A_FVEC  = 8'h44;
    localparam logic [AW-1:0] A_SRCH  = 8'h48;
    localparam logic [AW-1:0] A_SRCL  = 8'h4C;
    localparam logic [AW-1:0] A_FRCH  = 8'h50;
    localparam logic [AW-1:0] A_FRCL  = 8'h54;
    localparam logic [AW-1:0] A_NPH   = 8'h58;
    localparam logic [AW-1:0] A_NPL   = 8'h5C;
    localparam logic [AW-1:0] A_FPH   = 8'h60;
    localparam logic [AW-1:0] A_FPL   = 8'h64;

    localparam logic [4:0] THR_OFF = 5'h1f;

    typedef logic [NSRC-1:0][PW-1:0] prio_vec_t;

    typedef struct packed {
        logic           vld;
        logic [IDW-1:0] id;
        logic [PW-1:0]  pri;
    } pick_t;

    function automatic logic [DW-1:0] nvec_word(pick_t p);
        if (!p.vld) return '1;
        return {10'b0, p.id, 12'b0, p.pri};
    endfunction

    function automatic logic [DW-1:0] fvec_word(pick_t p);
        if (!p.vld) return '1;
        return {{(DW-IDW){1'b0}}, p.id};
    endfunction
endpackage

// File: rtl/prio_irq_regs.sv
module prio_irq_regs
    import prio_irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [AW-1:0]      addr,
    input  logic               we,
    input  logic [DW-1:0]      wdata,
    output logic [NSRC-1:0]    en_q,
    output logic [NSRC-1:0]    typ_q,
    output logic [NSRC-1:0]    frc_q,
    output prio_vec_t          prio_q,
    output logic [4:0]         thr_q,
    output logic [DW-1:0]      ctrl_q
);
    logic num_ok;
    assign num_ok = (wdata[DW-1:IDW] == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= '0;
            typ_q  <= '0;
            frc_q  <= '0;
            thr_q  <= THR_OFF;
            ctrl_q <= '0;
        end else if (we) begin
            case (addr)
                A_CTRL:  ctrl_q <= wdata;
                A_THR:   thr_q  <= wdata[4:0];
                A_ENSET: if (num_ok) en_q[wdata[IDW-1:0]] <= 1'b1;
                A_ENCLR: if (num_ok) en_q[wdata[IDW-1:0]] <= 1'b0;
                A_ENH:   en_q[NSRC-1:HALF]  <= wdata;
                A_ENL:   en_q[HALF-1:0]     <= wdata;
                A_TYH:   typ_q[NSRC-1:HALF] <= wdata;
                A_TYL:   typ_q[HALF-1:0]    <= wdata;
                A_FRCH:  frc_q[NSRC-1:HALF] <= wdata;
                A_FRCL:  frc_q[HALF-1:0]    <= wdata;
                default: ;
            endcase
        end
    end

    // Priority banks: bank k (sources 8k..8k+7) lives at A_PRIO + 4*(NBANK-1-k)
    for (genvar k = 0; k < NBANK; k++) begin : g_bank
        localparam logic [AW-1:0] BANK_A = A_PRIO + AW'(4 * (NBANK - 1 - k));
        logic [DW-1:0] bank_q;
        always_ff @(posedge clk) begin
            if (rst)                        bank_q <= '0;
            else if (we && addr == BANK_A)  bank_q <= wdata;
        end
        assign prio_q[k*PER_W +: PER_W] = bank_q;
    end

    // R2
    enset_chk: assert property (@(posedge clk) disable iff (rst)
        (we && addr == A_ENSET && num_ok) |=> en_q[$past(wdata[IDW-1:0])]);
    // R3
    enclr_chk: assert property (@(posedge clk) disable iff (rst)
        (we && addr == A_ENCLR && num_ok) |=> !en_q[$past(wdata[IDW-1:0])]);
    // R2
    enset_bad_chk: assert property (@(posedge clk) disable iff (rst)
        (we && (addr == A_ENSET || addr == A_ENCLR) && !num_ok) |=> $stable(en_q));
    // R1
    thr_rst_chk: assert property (@(posedge clk)
        rst |=> (thr_q == THR_OFF && en_q == '0 && ctrl_q == '0));
endmodule

// File: rtl/prio_irq_norm_arb.sv
module prio_irq_norm_arb
    import prio_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NSRC-1:0]   pend,
    input  prio_vec_t         prio,
    input  logic [4:0]        thr,
    output pick_t             pick
);
    logic [NSRC-1:0] elig;

    always_comb begin
        for (int n = 0; n < NSRC; n++)
            elig[n] = pend[n] && (thr == THR_OFF || prio[n] > thr[PW-1:0]);
    end

    // ascending scan with >= lets the larger source number win a tie
    always_comb begin
        pick = '0;
        for (int n = 0; n < NSRC; n++) begin
            if (elig[n] && (!pick.vld || prio[n] >= pick.pri)) begin
                pick.vld = 1'b1;
                pick.id  = IDW'(n);
                pick.pri = prio[n];
            end
        end
    end

    // R8
    above_thr_chk: assert property (@(posedge clk) disable iff (rst)
        pick.vld |-> (thr == THR_OFF || pick.pri > thr[PW-1:0]));
    // R7
    win_pend_chk: assert property (@(posedge clk) disable iff (rst)
        pick.vld |-> (pend[pick.id] && prio[pick.id] == pick.pri));
endmodule

// File: rtl/prio_irq_fast_arb.sv
module prio_irq_fast_arb
    import prio_irq_pkg::*;
(
    input  logic [NSRC-1:0] pend,
    output pick_t           pick
);
    always_comb begin
        pick = '0;
        for (int n = 0; n < NSRC; n++) begin
            if (pend[n]) begin
                pick.vld = 1'b1;
                pick.id  = IDW'(n);
            end
        end
    end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import prio_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [63:0]      src_i,
    input  logic [7:0]       bus_addr,
    input  logic             bus_we,
    input  logic [31:0]      bus_wdata,
    output logic [31:0]      bus_rdata,
    output logic             nirq_o,
    output logic             firq_o
);
    logic [NSRC-1:0] en_q, typ_q, frc_q, act, pend_n, pend_f;
    prio_vec_t       prio_q;
    logic [4:0]      thr_q;
    logic [DW-1:0]   ctrl_q, nvec, fvec;
    pick_t           npick, fpick;
    logic [2:0]      bsel;

    prio_irq_regs u_regs (
        .clk(clk), .rst(rst), .addr(bus_addr), .we(bus_we), .wdata(bus_wdata),
        .en_q(en_q), .typ_q(typ_q), .frc_q(frc_q), .prio_q(prio_q),
        .thr_q(thr_q), .ctrl_q(ctrl_q)
    );

    assign act    = src_i | frc_q;
    assign pend_n = act & en_q & ~typ_q;
    assign pend_f = act & en_q &  typ_q;

    prio_irq_norm_arb u_narb (
        .clk(clk), .rst(rst), .pend(pend_n), .prio(prio_q), .thr(thr_q), .pick(npick)
    );
    prio_irq_fast_arb u_farb (.pend(pend_f), .pick(fpick));

    assign nvec   = nvec_word(npick);
    assign fvec   = fvec_word(fpick);
    assign nirq_o = npick.vld;
    assign firq_o = |pend_f;
    assign bsel   = 3'(NBANK - 1) - bus_addr[4:2];

    always_comb begin
        case (bus_addr)
            A_CTRL:  bus_rdata = ctrl_q;
            A_THR:   bus_rdata = {27'b0, thr_q};
            A_ENH:   bus_rdata = en_q[NSRC-1:HALF];
            A_ENL:   bus_rdata = en_q[HALF-1:0];
            A_TYH:   bus_rdata = typ_q[NSRC-1:HALF];
            A_TYL:   bus_rdata = typ_q[HALF-1:0];
            A_NVEC:  bus_rdata = nvec;
            A_FVEC:  bus_rdata = fvec;
            A_SRCH:  bus_rdata = src_i[NSRC-1:HALF];
            A_SRCL:  bus_rdata = src_i[HALF-1:0];
            A_FRCH:  bus_rdata = frc_q[NSRC-1:HALF];
            A_FRCL:  bus_rdata = frc_q[HALF-1:0];
            A_NPH:   bus_rdata = pend_n[NSRC-1:HALF];
            A_NPL:   bus_rdata = pend_n[HALF-1:0];
            A_FPH:   bus_rdata = pend_f[NSRC-1:HALF];
            A_FPL:   bus_rdata = pend_f[HALF-1:0];
            default: begin
                if (bus_addr >= A_PRIO && bus_addr < A_NVEC && bus_addr[1:0] == 2'b00)
                    bus_rdata = prio_q[bsel*PER_W +: PER_W];
                else
                    bus_rdata = '0;
            end
        endcase
    end

    // R10
    nirq_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !nirq_o |-> (nvec == '1));
    // R10
    firq_vec_chk: assert property (@(posedge clk) disable iff (rst)
        firq_o |-> (fvec[DW-1:IDW] == '0 && pend_f[fvec[IDW-1:0]]));
    // R9
    fidle_chk: assert property (@(posedge clk) disable iff (rst)
        !firq_o |-> (fvec == '1));
    // R6
    path_excl_chk: assert property (@(posedge clk) disable iff (rst)
        (pend_n & pend_f) == '0);
endmodule

// File: tb/prio_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module prio_irq_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] src = '0;
    logic [7:0]  addr = '0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        nirq, firq;

    always #2.5 clk = ~clk;

    prio_irq_ctrl dut_i (
        .clk(clk), .rst(rst), .src_i(src), .bus_addr(addr), .bus_we(we),
        .bus_wdata(wdata), .bus_rdata(rdata), .nirq_o(nirq), .firq_o(firq)
    );

    int n_chk = 0, n_err = 0;
    bit done = 0;

    logic [63:0] m_en, m_ty, m_fr;
    logic [3:0]  m_pr [64];
    logic [4:0]  m_thr;
    logic [31:0] m_ctrl;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic void m_reset();
        m_en = '0; m_ty = '0; m_fr = '0; m_thr = 5'h1f; m_ctrl = '0;
        for (int i = 0; i < 64; i++) m_pr[i] = '0;
    endfunction

    function automatic logic [63:0] m_pn();
        return (src | m_fr) & m_en & ~m_ty;
    endfunction
    function automatic logic [63:0] m_pf();
        return (src | m_fr) & m_en & m_ty;
    endfunction

    function automatic logic [31:0] m_nvec();
        logic [63:0] p = m_pn();
        int best = -1;
        for (int i = 0; i < 64; i++)
            if (p[i] && (m_thr == 5'h1f || m_pr[i] > m_thr[3:0]))
                if (best < 0 || m_pr[i] >= m_pr[best]) best = i;
        if (best < 0) return 32'hFFFF_FFFF;
        return (32'(best) << 16) | 32'(m_pr[best]);
    endfunction

    function automatic logic [31:0] m_fvec();
        logic [63:0] p = m_pf();
        for (int i = 63; i >= 0; i--) if (p[i]) return 32'(i);
        return 32'hFFFF_FFFF;
    endfunction

    function automatic logic [31:0] m_read(logic [7:0] a);
        logic [31:0] w = '0;
        if (a >= 8'h20 && a <= 8'h3C) begin
            int k = 7 - int'((a - 8'h20) >> 2);
            for (int i = 0; i < 8; i++) w[4*i +: 4] = m_pr[8*k + i];
            return w;
        end
        case (a)
            8'h00: return m_ctrl;
            8'h04: return {27'b0, m_thr};
            8'h10: return m_en[63:32];
            8'h14: return m_en[31:0];
            8'h18: return m_ty[63:32];
            8'h1C: return m_ty[31:0];
            8'h40: return m_nvec();
            8'h44: return m_fvec();
            8'h48: return src[63:32];
            8'h4C: return src[31:0];
            8'h50: return m_fr[63:32];
            8'h54: return m_fr[31:0];
            8'h58: return m_pn()[63:32];
            8'h5C: return m_pn()[31:0];
            8'h60: return m_pf()[63:32];
            8'h64: return m_pf()[31:0];
            default: return '0;
        endcase
    endfunction

    function automatic string req_of(logic [7:0] a);
        if (a >= 8'h20 && a <= 8'h3C) return "R5";
        case (a)
            8'h40: return "R7";
            8'h44: return "R9";
            8'h58, 8'h5C, 8'h60, 8'h64: return "R6";
            8'h00, 8'h08, 8'h0C, 8'h68: return "R11";
            default: return "R4";
        endcase
    endfunction

    function automatic void m_write(logic [7:0] a, logic [31:0] d);
        if (a >= 8'h20 && a <= 8'h3C) begin
            int k = 7 - int'((a - 8'h20) >> 2);
            for (int i = 0; i < 8; i++) m_pr[8*k + i] = d[4*i +: 4];
            return;
        end
        case (a)
            8'h00: m_ctrl = d;
            8'h04: m_thr = d[4:0];
            8'h08: if (d < 64) m_en[d[5:0]] = 1'b1;
            8'h0C: if (d < 64) m_en[d[5:0]] = 1'b0;
            8'h10: m_en[63:32] = d;
            8'h14: m_en[31:0]  = d;
            8'h18: m_ty[63:32] = d;
            8'h1C: m_ty[31:0]  = d;
            8'h50: m_fr[63:32] = d;
            8'h54: m_fr[31:0]  = d;
            default: ;
        endcase
    endfunction

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(posedge clk);
        #1;
        we = 1'b0;
        m_write(a, d);
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic sweep(string tag);
        logic [31:0] d;
        for (int a = 0; a <= 8'h68; a += 4) begin
            rd(8'(a), d);
            chk({tag, "/", req_of(8'(a))}, d, m_read(8'(a)));
        end
        chk({tag, "/R10 nirq"}, {31'b0, nirq}, {31'b0, m_nvec() != 32'hFFFF_FFFF});
        chk({tag, "/R10 firq"}, {31'b0, firq}, {31'b0, m_pf() != '0});
    endtask

    task automatic set_src(logic [63:0] v);
        @(negedge clk);
        src = v;
    endtask

    initial begin
        logic [31:0] d;
        void'($urandom(32'd1357));
        m_reset();
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        sweep("R1");
        rd(8'h40, d); chk("R1 nvec", d, 32'hFFFF_FFFF);
        rd(8'h04, d); chk("R1 thr", d, 32'h1f);

        // R2 / R3 enable by number
        wr(8'h08, 5); wr(8'h08, 40); wr(8'h08, 70);
        rd(8'h14, d); chk("R2 en low", d, 32'h20);
        rd(8'h10, d); chk("R2 en high", d, 32'h100);
        wr(8'h0C, 5); wr(8'h0C, 64);
        rd(8'h14, d); chk("R3 en low", d, 32'h0);
        rd(8'h10, d); chk("R3 en high kept", d, 32'h100);

        // R11 write lands at the edge
        @(negedge clk);
        addr = 8'h00; wdata = 32'hDEAD_BEEF; we = 1'b1;
        #1 chk("R11 before edge", rdata, 32'h0);
        @(posedge clk); #1 we = 1'b0; m_write(8'h00, 32'hDEAD_BEEF);
        rd(8'h00, d); chk("R11 after edge", d, 32'hDEAD_BEEF);
        wr(8'h40, 32'h1234); wr(8'h5C, 32'hFFFF_FFFF);
        sweep("R11ro");

        // R5 priority layout, R7 tie
        wr(8'h3C, 32'h0000_00A0);
        wr(8'h08, 1);
        set_src(64'h2);
        rd(8'h40, d); chk("R5 src1 prio", d, 32'h0001_000A);
        wr(8'h20, 32'hA000_0000);
        wr(8'h08, 63);
        set_src(64'h8000_0000_0000_0002);
        rd(8'h40, d); chk("R7 tie high id", d, 32'h003F_000A);

        // R8 threshold edges
        wr(8'h04, 32'h0A);
        rd(8'h40, d); chk("R8 equal masked", d, 32'hFFFF_FFFF);
        chk("R10 nirq masked", {31'b0, nirq}, 32'h0);
        wr(8'h04, 32'h09);
        rd(8'h40, d); chk("R8 one below", d, 32'h003F_000A);
        wr(8'h04, 32'h1f);

        // R9 fast path and force (R6)
        wr(8'h18, 32'h100); wr(8'h1C, 32'h8);
        wr(8'h08, 3); wr(8'h54, 32'h8);
        rd(8'h44, d); chk("R9 fast id 3", d, 32'h3);
        set_src(src | (64'h1 << 40));
        rd(8'h44, d); chk("R9 fast id 40", d, 32'd40);
        chk("R10 firq", {31'b0, firq}, 32'h1);
        sweep("R6dir");

        // constrained random
        for (int it = 0; it < 200; it++) begin
            int op = $urandom_range(0, 9);
            logic [31:0] r = $urandom & $urandom;
            case (op)
                0: wr(8'h08, $urandom_range(0, 71));
                1: wr(8'h0C, $urandom_range(0, 71));
                2: wr(($urandom_range(0, 1) != 0) ? 8'h10 : 8'h14, r);
                3: wr(($urandom_range(0, 1) != 0) ? 8'h18 : 8'h1C, r);
                4: wr(($urandom_range(0, 1) != 0) ? 8'h50 : 8'h54, r & $urandom);
                5: begin
                    logic [31:0] p = '0;
                    for (int i = 0; i < 8; i++) p[4*i +: 4] = 4'($urandom_range(4, 7));
                    wr(8'(8'h20 + 4 * $urandom_range(0, 7)), p);
                end
                6: wr(8'h04, ($urandom_range(0, 3) == 0) ? 32'h1f : $urandom_range(3, 8));
                7: wr(8'(8'h40 + 4 * $urandom_range(0, 9)), $urandom);
                8: wr(8'h00, $urandom);
                default: set_src({$urandom & $urandom, $urandom & $urandom});
            endcase
            if (it % 8 == 7) sweep("RND");
            else begin
                rd(8'h40, d); chk("R7 rnd", d, m_nvec());
                rd(8'h44, d); chk("R9 rnd", d, m_fvec());
            end
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end
endmodule